// File: doc/BRIEF.md
# Key-Locked ECC RAM Wrapper

This block is a word-wide single-port RAM with single-error-correct, double-error-detect protection. Every written 32-bit word is stored together with seven check bits. On a read the stored codeword is checked. A single flipped bit is repaired when repair is allowed, and a double flip is reported as uncorrectable. Error checking is off after reset. It is turned on through a small register port.

Two 4-bit control fields set the behaviour. Only an exact key value changes them, so a stray write cannot alter the protection state. The protection field turns checking on when it receives 4'b0101. The correction-lock field turns single-bit repair off when it receives 4'b1010. A mode input selects a configuration-memory variant. In that variant the protection field is a plain on/off switch. A fault-injection mask on the write path flips chosen bits of the stored codeword, so that the error paths can be exercised.

Top module: `ecc_lock_ram`

## Requirements
- R1: After reset, protection is off and correction is on. With protection off, a read returns the stored data bits unchanged and raises neither error flag.
- R2: In normal mode (cfg_mode=0), writing 4'b0101 to the protection field (reg_sel=0) turns protection on. Any other value written there leaves the state unchanged, and nothing but reset turns protection off.
- R3: Writing 4'b1010 to the correction-lock field (reg_sel=1) turns single-bit repair off. Any other value written there leaves the state unchanged.
- R4: In configuration mode (cfg_mode=1), a write to the protection field sets protection to bit 0 of the written value, so it can be switched both on and off.
- R5: Check bits are always generated on a write, including while protection is off. A word written while protection is off is checked correctly once protection is later turned on.
- R6: With protection and correction on, a read of a word with one flipped data bit returns the original data and raises err_single.
- R7: With protection on and correction off, a single-bit error returns the raw stored data and still raises err_single.
- R8: A double-bit error raises err_double, returns the raw stored data and never raises err_single, whatever the correction setting is.
- R9: With protection on, a read of an undamaged word returns the written data with both flags low.
- R10: Read data, rd_valid and the error flags appear one clock after the read is accepted, for exactly one cycle. Error flags are high only together with rd_valid.
- R11: A single flip that lands in a check bit (ram_flip bits 38..32) leaves the data unchanged and raises err_single. The stored codeword layout is {check[6:0], data[31:0]}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 1 | 1 selects the configuration-memory variant of the protection field |
| reg_wr | input | 1 | Control-field write strobe |
| reg_sel | input | 1 | 0 = protection field, 1 = correction-lock field |
| reg_wdata | input | 4 | Value written to the selected field |
| ram_en | input | 1 | RAM access request |
| ram_we | input | 1 | 1 = write, 0 = read |
| ram_addr | input | ADDR_W | Word address |
| ram_wdata | input | 32 | Write data |
| ram_flip | input | 39 | Bits XORed into the stored codeword on a write (fault injection) |
| ram_rdata | output | 32 | Read data, corrected or raw |
| rd_valid | output | 1 | Read data valid strobe |
| err_single | output | 1 | Single-bit error seen on this read |
| err_double | output | 1 | Uncorrectable error seen on this read |

## Verification
Wrong key-field state has no output of its own. It shows up on the next read of a damaged word: a flag that should be there is missing, a flag appears that should not, or the data is corrected when it should come back raw. That read completes one clock after it is issued. Each control-field write is therefore followed by a read of a word with a known planted flip. A syndrome or bit-position fault appears as wrong data on the same read that carries the flag.

// File: rtl/ecc_lock_pkg.sv
package ecc_lock_pkg;
   localparam int ECC_DW  = 32;
   localparam int ECC_SW  = 6;
   localparam int ECC_CW  = ECC_SW + 1;
   localparam int ECC_TW  = ECC_DW + ECC_CW;

   // Hamming position of data bit j (skips powers of two)
   function automatic int data_pos(input int j);
      if (j < 1)       return 3;
      else if (j < 4)  return j + 4;
      else if (j < 11) return j + 5;
      else if (j < 26) return j + 6;
      else             return j + 7;
   endfunction

   function automatic logic [ECC_CW-1:0] ecc_encode(input logic [ECC_DW-1:0] d);
      logic [ECC_CW-1:0] c;
      c = '0;
      for (int j = 0; j < ECC_DW; j++) begin
         for (int i = 0; i < ECC_SW; i++) begin
            if (((data_pos(j) >> i) & 1) != 0) c[i] = c[i] ^ d[j];
         end
      end
      c[ECC_CW-1] = ^{d, c[ECC_SW-1:0]};
      return c;
   endfunction
endpackage

// File: rtl/ecc_lock_ctrl.sv
module ecc_lock_ctrl #(
   parameter int              FIELD_W    = 4,
   parameter logic [FIELD_W-1:0] KEY_EN     = 4'b0101,
   parameter logic [FIELD_W-1:0] KEY_NOCORR = 4'b1010
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_mode,
   input  logic               reg_wr,
   input  logic               reg_sel,
   input  logic [FIELD_W-1:0] reg_wdata,
   output logic               prot_en,
   output logic               corr_en
);
   logic wr_prot, wr_lock;
   assign wr_prot = reg_wr && !reg_sel;
   assign wr_lock = reg_wr &&  reg_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prot_en <= 1'b0;
      end else if (wr_prot) begin
         if (cfg_mode)                prot_en <= reg_wdata[0];
         else if (reg_wdata == KEY_EN) prot_en <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 corr_en <= 1'b1;
      else if (wr_lock && reg_wdata == KEY_NOCORR) corr_en <= 1'b0;
   end
endmodule

// File: rtl/ecc_lock_mem.sv
module ecc_lock_mem
   import ecc_lock_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DEPTH  = 256
) (
   input  logic              clk,
   input  logic              ram_en,
   input  logic              ram_we,
   input  logic [ADDR_W-1:0] ram_addr,
   input  logic [ECC_DW-1:0] ram_wdata,
   input  logic [ECC_TW-1:0] ram_flip,
   output logic [ECC_TW-1:0] cw_q
);
   logic [ECC_TW-1:0] store [DEPTH];
   logic [ECC_TW-1:0] cw_wr;

   assign cw_wr = {ecc_encode(ram_wdata), ram_wdata} ^ ram_flip;

   always_ff @(posedge clk) begin
      if (ram_en) begin
         if (ram_we) store[ram_addr] <= cw_wr;
         else        cw_q            <= store[ram_addr];
      end
   end
endmodule

// File: rtl/ecc_lock_dec.sv
module ecc_lock_dec
   import ecc_lock_pkg::*;
(
   input  logic              valid,
   input  logic              prot,
   input  logic              corr,
   input  logic [ECC_TW-1:0] cw,
   output logic [ECC_DW-1:0] data,
   output logic              single,
   output logic              double
);
   logic [ECC_DW-1:0] raw;
   logic [ECC_CW-1:0] chk;
   logic [ECC_SW-1:0] syn;
   logic              par_bad;
   logic [ECC_DW-1:0] fix_mask;

   assign raw     = cw[ECC_DW-1:0];
   assign chk     = cw[ECC_TW-1:ECC_DW];
   assign syn     = ecc_encode(raw)[ECC_SW-1:0] ^ chk[ECC_SW-1:0];
   assign par_bad = ^cw;

   always_comb begin
      fix_mask = '0;
      for (int j = 0; j < ECC_DW; j++) begin
         fix_mask[j] = (data_pos(j) == int'(syn));
      end
   end

   assign single = valid && prot && par_bad;
   assign double = valid && prot && !par_bad && (syn != '0);
   assign data   = (single && corr) ? (raw ^ fix_mask) : raw;
endmodule

// File: rtl/ecc_lock_ram.sv
module ecc_lock_ram
   import ecc_lock_pkg::*;
#(
   parameter int          DATA_W     = 32,
   parameter int          ADDR_W     = 8,
   parameter int          DEPTH      = 256,
   parameter int          FIELD_W    = 4,
   parameter logic [3:0]  KEY_EN     = 4'b0101,
   parameter logic [3:0]  KEY_NOCORR = 4'b1010,
   parameter bit          OUT_REG    = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_mode,
   input  logic               reg_wr,
   input  logic               reg_sel,
   input  logic [3:0]         reg_wdata,
   input  logic               ram_en,
   input  logic               ram_we,
   input  logic [ADDR_W-1:0]  ram_addr,
   input  logic [31:0]        ram_wdata,
   input  logic [38:0]        ram_flip,
   output logic [31:0]        ram_rdata,
   output logic               rd_valid,
   output logic               err_single,
   output logic               err_double
);
   localparam int TW = DATA_W + ECC_CW;

   if (DATA_W != ECC_DW) begin : g_bad_width
      $error("ecc_lock_ram: DATA_W must equal %0d", ECC_DW);
   end
   if (FIELD_W != 4) begin : g_bad_field
      $error("ecc_lock_ram: FIELD_W must be 4");
   end
   if (DEPTH < 2 || DEPTH > (1 << ADDR_W)) begin : g_bad_depth
      $error("ecc_lock_ram: DEPTH out of range for ADDR_W");
   end
   if (KEY_EN == KEY_NOCORR) begin : g_bad_keys
      $error("ecc_lock_ram: keys must differ");
   end

   logic          prot_en, corr_en;
   logic [TW-1:0] cw_q;
   logic          rv_q, rd_prot, rd_corr;
   logic [31:0]   dec_data;
   logic          dec_single, dec_double;

   ecc_lock_ctrl #(.FIELD_W(FIELD_W), .KEY_EN(KEY_EN), .KEY_NOCORR(KEY_NOCORR)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .reg_wr(reg_wr),
      .reg_sel(reg_sel), .reg_wdata(reg_wdata), .prot_en(prot_en), .corr_en(corr_en)
   );

   ecc_lock_mem #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_mem (
      .clk(clk), .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .ram_flip(ram_flip), .cw_q(cw_q)
   );

   // settings captured with the read so a mid-flight key write cannot split a result
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rv_q    <= 1'b0;
         rd_prot <= 1'b0;
         rd_corr <= 1'b1;
      end else begin
         rv_q <= ram_en && !ram_we;
         if (ram_en && !ram_we) begin
            rd_prot <= prot_en;
            rd_corr <= corr_en;
         end
      end
   end

   ecc_lock_dec u_dec (
      .valid(rv_q), .prot(rd_prot), .corr(rd_corr), .cw(cw_q),
      .data(dec_data), .single(dec_single), .double(dec_double)
   );

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ram_rdata  <= '0;
            rd_valid   <= 1'b0;
            err_single <= 1'b0;
            err_double <= 1'b0;
         end else begin
            ram_rdata  <= dec_data;
            rd_valid   <= rv_q;
            err_single <= dec_single;
            err_double <= dec_double;
         end
      end
   end else begin : g_out_comb
      assign ram_rdata  = dec_data;
      assign rd_valid   = rv_q;
      assign err_single = dec_single;
      assign err_double = dec_double;
   end
endmodule

// File: rtl/ecc_lock_ram_chk.sv
module ecc_lock_ram_chk #(
   parameter logic [3:0] KEY_EN     = 4'b0101,
   parameter logic [3:0] KEY_NOCORR = 4'b1010,
   parameter bit         OUT_REG    = 1'b0
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_mode,
   input logic       reg_wr,
   input logic       reg_sel,
   input logic [3:0] reg_wdata,
   input logic       ram_en,
   input logic       ram_we,
   input logic       rd_valid,
   input logic       err_single,
   input logic       err_double,
   input logic       prot_en,
   input logic       corr_en,
   input logic       rd_prot
);
   assert_prot_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prot_en) |-> $past(reg_wr && !reg_sel &&
                               (cfg_mode ? reg_wdata[0] : (reg_wdata == KEY_EN))));

   assert_prot_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prot_en) |-> $past(cfg_mode && reg_wr && !reg_sel));

   assert_lock_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(corr_en) |-> $past(reg_wr && reg_sel && (reg_wdata == KEY_NOCORR)));

   assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(corr_en));

   assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({err_single, err_double}));

   assert_flags_with_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (err_single || err_double) |-> rd_valid);

   if (OUT_REG) begin : g_lat2
      assert_read_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (ram_en && !ram_we) |=> ##1 rd_valid);
      assert_quiet_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (err_single || err_double) |-> $past(rd_prot));
   end else begin : g_lat1
      assert_read_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (ram_en && !ram_we) |=> rd_valid);
      assert_valid_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
         rd_valid |-> $past(ram_en && !ram_we));
      assert_quiet_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (err_single || err_double) |-> rd_prot);
   end
endmodule

bind ecc_lock_ram ecc_lock_ram_chk #(
   .KEY_EN(KEY_EN), .KEY_NOCORR(KEY_NOCORR), .OUT_REG(OUT_REG)
) i_chk (
   .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .reg_wr(reg_wr), .reg_sel(reg_sel),
   .reg_wdata(reg_wdata), .ram_en(ram_en), .ram_we(ram_we), .rd_valid(rd_valid),
   .err_single(err_single), .err_double(err_double), .prot_en(prot_en),
   .corr_en(corr_en), .rd_prot(rd_prot)
);

// File: tb/test_ecc_lock_ram.sv
module test_ecc_lock_ram;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_mode = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_sel = 1'b0;
   logic [3:0]  reg_wdata = '0;
   logic        ram_en = 1'b0;
   logic        ram_we = 1'b0;
   logic [7:0]  ram_addr = '0;
   logic [31:0] ram_wdata = '0;
   logic [38:0] ram_flip = '0;
   logic [31:0] ram_rdata;
   logic        rd_valid, err_single, err_double;

   int n_checks = 0;
   int n_errs   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ecc_lock_ram i_ecc_lock_ram (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .ram_flip(ram_flip), .ram_rdata(ram_rdata),
      .rd_valid(rd_valid), .err_single(err_single), .err_double(err_double)
   );

   typedef struct packed {
      logic [7:0]  addr;
      logic [31:0] data;
      logic [38:0] flip;
      logic [31:0] exp;
      logic        exp_s;
      logic        exp_d;
   } vec_t;

   // protection on, correction on
   localparam vec_t VEC [7] = '{
      '{8'd1, 32'hA5A5_0F0F, 39'h00_0000_0000, 32'hA5A5_0F0F, 1'b0, 1'b0}, // R9
      '{8'd2, 32'h3C3C_C3C3, 39'h00_0000_0001, 32'h3C3C_C3C3, 1'b1, 1'b0}, // R6
      '{8'd3, 32'h8000_0001, 39'h00_8000_0000, 32'h8000_0001, 1'b1, 1'b0}, // R6
      '{8'd4, 32'h5555_AAAA, 39'h01_0000_0000, 32'h5555_AAAA, 1'b1, 1'b0}, // R11
      '{8'd5, 32'h0000_0000, 39'h40_0000_0000, 32'h0000_0000, 1'b1, 1'b0}, // R11
      '{8'd6, 32'hCAFE_F00D, 39'h00_0002_0008, 32'hCAFC_F005, 1'b0, 1'b1}, // R8
      '{8'd7, 32'h0F0F_F0F0, 39'h02_0000_0020, 32'h0F0F_F0D0, 1'b0, 1'b1}  // R8
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic reg_write(input logic sel, input logic [3:0] val);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic ram_write(input logic [7:0] a, input logic [31:0] d, input logic [38:0] f);
      @(negedge clk);
      ram_en = 1'b1; ram_we = 1'b1; ram_addr = a; ram_wdata = d; ram_flip = f;
      @(negedge clk);
      ram_en = 1'b0; ram_we = 1'b0; ram_flip = '0;
   endtask

   // read, check data and flags one cycle later, then check the strobe has dropped (R10)
   task automatic expect_read(input string req, input logic [7:0] a, input logic [31:0] exp,
                              input logic es, input logic ed);
      @(negedge clk);
      ram_en = 1'b1; ram_we = 1'b0; ram_addr = a;
      @(negedge clk);
      ram_en = 1'b0;
      chk({req, " data"}, ram_rdata, exp);
      chk({req, " flags"}, {29'd0, rd_valid, err_single, err_double}, {29'd0, 1'b1, es, ed});
      @(negedge clk);
      chk("R10 pulse", {29'd0, rd_valid, err_single, err_double}, 32'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_errs++;
         n_checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1 reset state
      chk("R1 reset", {29'd0, rd_valid, err_single, err_double}, 32'd0);

      // R5 word written with protection off, R1 unchecked read
      ram_write(8'd10, 32'h1357_9BDF, 39'h10);
      expect_read("R1 off raw", 8'd10, 32'h1357_9BCF, 1'b0, 1'b0);

      // R2 wrong key ignored
      reg_write(1'b0, 4'b0011);
      expect_read("R2 bad key", 8'd10, 32'h1357_9BCF, 1'b0, 1'b0);
      reg_write(1'b0, 4'b1010);
      expect_read("R2 other key", 8'd10, 32'h1357_9BCF, 1'b0, 1'b0);

      // R2 right key, R5 old word now corrected
      reg_write(1'b0, 4'b0101);
      expect_read("R5 late check", 8'd10, 32'h1357_9BDF, 1'b1, 1'b0);

      // R2 no way back in normal mode
      reg_write(1'b0, 4'b0000);
      expect_read("R2 sticky", 8'd10, 32'h1357_9BDF, 1'b1, 1'b0);

      // table walk: R6 R8 R9 R11
      foreach (VEC[i]) ram_write(VEC[i].addr, VEC[i].data, VEC[i].flip);
      foreach (VEC[i]) expect_read("R6/R8/R9/R11 table", VEC[i].addr, VEC[i].exp,
                                   VEC[i].exp_s, VEC[i].exp_d);

      // R3 wrong key on lock field
      reg_write(1'b1, 4'b0101);
      expect_read("R3 bad key", 8'd10, 32'h1357_9BDF, 1'b1, 1'b0);

      // R3 right key, R7 raw data with flag
      reg_write(1'b1, 4'b1010);
      expect_read("R7 raw single", 8'd10, 32'h1357_9BCF, 1'b1, 1'b0);
      expect_read("R7 raw check-bit", 8'd4, 32'h5555_AAAA, 1'b1, 1'b0);
      expect_read("R8 corr off", 8'd6, 32'hCAFC_F005, 1'b0, 1'b1);

      // R4 configuration variant after reset
      do_reset();
      cfg_mode = 1'b1;
      ram_write(8'd20, 32'hDEAD_BEEF, 39'h200);
      expect_read("R4 default off", 8'd20, 32'hDEAD_BCEF, 1'b0, 1'b0);
      reg_write(1'b0, 4'b0001);
      expect_read("R4 on", 8'd20, 32'hDEAD_BEEF, 1'b1, 1'b0);
      reg_write(1'b0, 4'b0100);
      expect_read("R4 off", 8'd20, 32'hDEAD_BCEF, 1'b0, 1'b0);
      reg_write(1'b0, 4'b1111);
      expect_read("R4 on again", 8'd20, 32'hDEAD_BEEF, 1'b1, 1'b0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end
endmodule